// File: doc/BRIEF.md
# Disk Controller Host Register Interface

This block is the processor-facing register window of a host adapter that talks to a disk controller over a byte-wide, handshaked bus. The processor sees four I/O ports whose base is chosen by a strap input. Through them it can send bytes to the controller, collect bytes the controller returns, set a control byte that drives controller selection and the interrupt and DMA enables, and read a status byte. That status byte shows the controller's bus phase lines together with three adapter flags.

On the controller side every signal is active low. The block inverts each pin at the boundary, so all internal and register-visible bits are active high. Odd parity is generated on outgoing bytes and checked on every captured incoming byte. Each processor access to the data port is answered by a one-cycle acknowledge pulse to the controller. A separate DMA engine and a boot-overlay circuit connect through plain strobes: a DONE level, a completion-status load strobe, an address-byte write strobe and a port-3 read strobe.

The processor-side interface is a plain register bus with no back-pressure. A read returns data combinationally in the cycle it is issued. A write takes effect at the clock edge it is presented on.

Top module: `dskhost_regif`

## Requirements
- R1: A port access is decoded only when the upper address bits equal the base input. In narrow mode `io_addr[7:2]` is compared with `base_sel[5:0]` and `io_addr[15:8]` is ignored. In wide mode `io_addr[15:2]` is compared with `base_sel[13:0]`. `io_addr[1:0]` selects port 0 data, 1 control/completion, 2 status, 3 auxiliary.
- R2: A write to port 1 loads the control byte. Bit 6 is select, bit 4 is interrupt enable, bit 3 is request-interrupt enable, bit 1 is data enable and bit 0 is DMA enable (output `dma_en`). Bits 7, 5 and 2 have no effect on any output.
- R3: A write to port 0 loads the outgoing latch, which holds until the next port-0 write. When data enable is set and the controller direction is toward the controller, `ctl_tx_oe` is 1 and `ctl_tx_n` carries the inverted latch. `ctl_tx_par_n` carries the inverted odd-parity bit of the driven byte.
- R4: While control bit 6 is set, `ctl_sel_n` is 0, `ctl_tx_oe` is 1 and driven data bit 0 is 1 (pin 0 low).
- R5: On the clock edge where request first becomes active while the direction is toward the host, the inverted incoming byte is captured. A port-0 read returns it until the next such capture; pin changes in between have no effect.
- R6: A captured byte whose 8 data bits plus parity bit hold an even number of ones sets the parity error flag (status bit 2). Any port-1 write clears it.
- R7: A port-2 read returns status bit 7 request, bit 6 direction (1 = toward controller), bit 5 message, bit 4 command (1) or data (0), bit 3 busy, bit 2 parity error, bit 1 interrupt active and bit 0 DONE. Bits 7 to 3 are the inverted controller pins.
- R8: If both interrupt enables are set while request is active, `irq` becomes 1 at the next edge. It stays 1 after request drops and clears on the edge of a port-2 read; setting wins if both occur together.
- R9: A decoded port-0 read or write makes `ctl_ack_n` 0 for exactly the following clock cycle.
- R10: A pulse on `cstat_ld` captures the inverted incoming pins into the completion register. A port-1 read returns that register.
- R11: A decoded port-3 write raises `dma_addr_wr` in the same cycle, with `io_wdata` on `dma_addr_byte`. A decoded port-3 read raises `boot_off_rd` in the same cycle.
- R12: Status bit 0 follows the `dma_done` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | Processor I/O address |
| io_rd | input | 1 | Processor read cycle |
| io_wr | input | 1 | Processor write cycle |
| io_wdata | input | 8 | Processor write data |
| io_rdata | output | 8 | Processor read data, 0 when not reading a decoded port |
| base_sel | input | 14 | Base address straps |
| wide_io | input | 1 | 1 = 16-bit decoding, 0 = 8-bit decoding |
| dma_done | input | 1 | DONE level from the DMA engine |
| cstat_ld | input | 1 | Completion status load strobe |
| dma_en | output | 1 | DMA enable control bit |
| dma_addr_wr | output | 1 | Port-3 write strobe |
| dma_addr_byte | output | 8 | Byte for the DMA address register |
| boot_off_rd | output | 1 | Port-3 read strobe |
| irq | output | 1 | Interrupt request, active high |
| ctl_rx_n | input | 8 | Incoming controller data, active low |
| ctl_rx_par_n | input | 1 | Incoming parity, active low |
| ctl_tx_n | output | 8 | Outgoing controller data, active low |
| ctl_tx_par_n | output | 1 | Outgoing parity, active low |
| ctl_tx_oe | output | 1 | Output enable for the outgoing data pins |
| ctl_req_n | input | 1 | Controller request, active low |
| ctl_io_n | input | 1 | Direction, low = toward controller |
| ctl_msg_n | input | 1 | Message phase, active low |
| ctl_cd_n | input | 1 | Command phase, active low |
| ctl_busy_n | input | 1 | Controller busy, active low |
| ctl_sel_n | output | 1 | Controller select, active low |
| ctl_ack_n | output | 1 | Acknowledge, active low |

## Verification
Several properties are checked in every cycle:
- the interrupt flag holds until a status read;
- the parity flag clears after a control write with no bad capture;
- the outgoing latch and captured byte stay stable outside their load events;
- at most one port strobe is decoded;
- select always forces the bus drive and bit 0.

The bench scenarios cover the rest, computing expected values from the register layout:
- which address patterns decode in each mode;
- the exact bit positions of status and control;
- the parity generated for arbitrary bytes and the parity judged on bad incoming bytes;
- the acknowledge pulse timing;
- the auxiliary strobes.

// File: rtl/dskhost_pkg.sv
package dskhost_pkg;
  localparam int DW = 8;
  localparam int PB = 2;
  localparam int NP = 1 << PB;

  localparam int PORT_DATA = 0;
  localparam int PORT_CTRL = 1;
  localparam int PORT_STAT = 2;
  localparam int PORT_AUX  = 3;

  localparam int CB_SEL   = 6;
  localparam int CB_IEN   = 4;
  localparam int CB_REQIE = 3;
  localparam int CB_DEN   = 1;
  localparam int CB_DMA   = 0;

  typedef struct packed {
    logic req;
    logic to_ctl;
    logic msg;
    logic cmd;
    logic busy;
  } phase_t;

  function automatic logic odd_fill(input logic [DW-1:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/dskhost_decode.sv
module dskhost_decode
  import dskhost_pkg::*;
#(
  parameter int AW = 16,
  parameter int NW = 8
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-PB-1:0] base,
  input  logic             wide,
  input  logic             rd,
  input  logic             wr,
  output logic [NP-1:0]    rstb,
  output logic [NP-1:0]    wstb
);
  localparam int BW = AW - PB;
  localparam int NB = NW - PB;

  logic hit;
  always_comb begin
    if (wide) hit = (addr[AW-1:PB] == base);
    else      hit = (addr[NW-1:PB] == base[NB-1:0]);
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign rstb[p] = hit && rd && (addr[PB-1:0] == p[PB-1:0]);
    assign wstb[p] = hit && wr && (addr[PB-1:0] == p[PB-1:0]);
  end

  always_comb begin
    p_one_port_r1: assert ($onehot0({rstb, wstb}) || (rd && wr));
  end
endmodule

// File: rtl/dskhost_link.sv
module dskhost_link
  import dskhost_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_pin_n,
  input  logic          rx_par_n,
  input  logic          req_n,
  input  logic          io_n,
  input  logic          msg_n,
  input  logic          cd_n,
  input  logic          busy_n,
  input  logic [DW-1:0] tx_latch,
  input  logic          sel_on,
  input  logic          data_en,
  input  logic          ack_req,
  output logic [DW-1:0] tx_pin_n,
  output logic          tx_par_n,
  output logic          tx_oe,
  output logic          sel_n,
  output logic          ack_n,
  output phase_t        phase,
  output logic [DW-1:0] rx_now,
  output logic [DW-1:0] rx_byte,
  output logic          rx_fire,
  output logic          rx_bad
);
  logic [DW-1:0] tx_byte;
  logic          req_q, ack_q;

  assign phase   = '{req: ~req_n, to_ctl: ~io_n, msg: ~msg_n, cmd: ~cd_n, busy: ~busy_n};
  assign rx_now  = ~rx_pin_n;
  assign rx_fire = phase.req && !req_q && !phase.to_ctl;
  assign rx_bad  = ~(^{rx_now, ~rx_par_n});

  assign tx_byte  = tx_latch | {{(DW-1){1'b0}}, sel_on};
  assign tx_pin_n = ~tx_byte;
  assign tx_par_n = ~odd_fill(tx_byte);
  assign tx_oe    = sel_on || (data_en && phase.to_ctl);
  assign sel_n    = ~sel_on;
  assign ack_n    = ~ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      rx_byte <= '0;
    end else begin
      req_q <= phase.req;
      ack_q <= ack_req;
      if (rx_fire) rx_byte <= rx_now;
    end
  end

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_fire |=> $stable(rx_byte));
  p_sel_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> (tx_oe && !tx_pin_n[0]));
endmodule

// File: rtl/dskhost_regs.sv
module dskhost_regs
  import dskhost_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] rstb,
  input  logic [NP-1:0] wstb,
  input  logic [DW-1:0] wdata,
  input  phase_t        phase,
  input  logic [DW-1:0] rx_now,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_fire,
  input  logic          rx_bad,
  input  logic          cstat_ld,
  input  logic          done,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] dout,
  output logic          irq,
  output logic [DW-1:0] rdata
);
  logic          perr;
  logic [DW-1:0] cstat;
  logic          irq_set;

  assign irq_set = ctrl[CB_IEN] && ctrl[CB_REQIE] && phase.req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      dout  <= '0;
      cstat <= '0;
      perr  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (wstb[PORT_CTRL]) ctrl <= wdata;
      if (wstb[PORT_DATA]) dout <= wdata;
      if (cstat_ld)        cstat <= rx_now;
      perr <= (rx_fire && rx_bad) || (perr && !wstb[PORT_CTRL]);
      irq  <= irq_set || (irq && !rstb[PORT_STAT]);
    end
  end

  always_comb begin
    rdata = '0;
    if (rstb[PORT_DATA]) rdata = rx_byte;
    if (rstb[PORT_CTRL]) rdata = cstat;
    if (rstb[PORT_STAT]) rdata = {phase.req, phase.to_ctl, phase.msg, phase.cmd,
                                  phase.busy, perr, irq, done};
  end

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rstb[PORT_STAT]) |=> irq);
  p_perr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb[PORT_CTRL] && !(rx_fire && rx_bad)) |=> !perr);
  p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb[PORT_DATA] |=> $stable(dout));
endmodule

// File: rtl/dskhost_regif.sv
module dskhost_regif
  import dskhost_pkg::*;
#(
  parameter int AW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic [AW-PB-1:0] base_sel,
  input  logic          wide_io,
  input  logic          dma_done,
  input  logic          cstat_ld,
  output logic          dma_en,
  output logic          dma_addr_wr,
  output logic [DW-1:0] dma_addr_byte,
  output logic          boot_off_rd,
  output logic          irq,
  input  logic [DW-1:0] ctl_rx_n,
  input  logic          ctl_rx_par_n,
  output logic [DW-1:0] ctl_tx_n,
  output logic          ctl_tx_par_n,
  output logic          ctl_tx_oe,
  input  logic          ctl_req_n,
  input  logic          ctl_io_n,
  input  logic          ctl_msg_n,
  input  logic          ctl_cd_n,
  input  logic          ctl_busy_n,
  output logic          ctl_sel_n,
  output logic          ctl_ack_n
);
  logic [NP-1:0] rstb, wstb;
  logic [DW-1:0] ctrl, dout, rx_now, rx_byte;
  logic          rx_fire, rx_bad;
  phase_t        phase;

  dskhost_decode #(.AW(AW), .NW(NW)) u_decode (
    .addr(io_addr), .base(base_sel), .wide(wide_io),
    .rd(io_rd), .wr(io_wr), .rstb(rstb), .wstb(wstb)
  );

  dskhost_link u_link (
    .clk(clk), .rst_n(rst_n),
    .rx_pin_n(ctl_rx_n), .rx_par_n(ctl_rx_par_n), .req_n(ctl_req_n),
    .io_n(ctl_io_n), .msg_n(ctl_msg_n), .cd_n(ctl_cd_n), .busy_n(ctl_busy_n),
    .tx_latch(dout), .sel_on(ctrl[CB_SEL]), .data_en(ctrl[CB_DEN]),
    .ack_req(rstb[PORT_DATA] | wstb[PORT_DATA]),
    .tx_pin_n(ctl_tx_n), .tx_par_n(ctl_tx_par_n), .tx_oe(ctl_tx_oe),
    .sel_n(ctl_sel_n), .ack_n(ctl_ack_n), .phase(phase),
    .rx_now(rx_now), .rx_byte(rx_byte), .rx_fire(rx_fire), .rx_bad(rx_bad)
  );

  dskhost_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rstb(rstb), .wstb(wstb), .wdata(io_wdata),
    .phase(phase), .rx_now(rx_now), .rx_byte(rx_byte), .rx_fire(rx_fire),
    .rx_bad(rx_bad), .cstat_ld(cstat_ld), .done(dma_done),
    .ctrl(ctrl), .dout(dout), .irq(irq), .rdata(io_rdata)
  );

  assign dma_en        = ctrl[CB_DMA];
  assign dma_addr_wr   = wstb[PORT_AUX];
  assign dma_addr_byte = io_wdata;
  assign boot_off_rd   = rstb[PORT_AUX];
endmodule

// File: tb/dskhost_regif_tb.sv
module dskhost_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic [13:0] base_sel = 14'h2A5C;
  logic        wide_io = 1'b1, dma_done = 1'b0, cstat_ld = 1'b0;
  logic        dma_en, dma_addr_wr, boot_off_rd, irq;
  logic [7:0]  dma_addr_byte, ctl_rx_n = 8'hFF, ctl_tx_n;
  logic        ctl_rx_par_n = 1'b1, ctl_tx_par_n, ctl_tx_oe;
  logic        ctl_req_n = 1'b1, ctl_io_n = 1'b1, ctl_msg_n = 1'b1, ctl_cd_n = 1'b1, ctl_busy_n = 1'b1;
  logic        ctl_sel_n, ctl_ack_n;

  int checks = 0, errors = 0;
  logic finished = 1'b0;

  localparam logic [15:0] WBASE = 16'hA970;
  localparam logic [15:0] NBASE = 16'h0070;

  always #5 clk = ~clk;

  dskhost_regif u_dut (.*);

  function automatic logic oddp(input logic [7:0] d);
    return ~(^d);
  endfunction

  function automatic logic [7:0] stat_exp(input logic req, toc, msg, cmd, busy, pe, iq, dn);
    return {req, toc, msg, cmd, busy, pe, iq, dn};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic req_pulse();
    ctl_req_n = 1'b0;
    @(negedge clk);
    ctl_req_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b;
    logic good, pe, toc, rq;
    void'($urandom(32'd7));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R7 reset status", {24'd0, io_rdata}, 32'd0);
    rd(WBASE + 2, v);
    chk("R7 reset status read", {24'd0, v}, 32'd0);
    chk("R8 reset irq", {31'd0, irq}, 32'd0);
    chk("R4 reset sel", {31'd0, ctl_sel_n}, 32'd1);
    chk("R9 reset ack", {31'd0, ctl_ack_n}, 32'd1);
    chk("R3 reset oe", {31'd0, ctl_tx_oe}, 32'd0);

    // R1 decoding
    wr(WBASE + 1 ^ 16'h0100, 8'h40);
    chk("R1 wide mismatch", {31'd0, ctl_sel_n}, 32'd1);
    wr(NBASE + 1, 8'h40);
    chk("R1 wide ignores narrow alias", {31'd0, ctl_sel_n}, 32'd1);
    wide_io = 1'b0;
    wr(16'h3471, 8'h40);
    chk("R1 narrow ignores upper bits", {31'd0, ctl_sel_n}, 32'd0);
    wr(16'h3475, 8'h00);
    chk("R1 narrow mismatch", {31'd0, ctl_sel_n}, 32'd0);
    wide_io = 1'b1;
    wr(WBASE + 1, 8'h00);
    chk("R1 wide hit", {31'd0, ctl_sel_n}, 32'd1);

    // R4 select forces drive and bit 0
    wr(WBASE + 0, 8'h00);
    wr(WBASE + 1, 8'h40);
    chk("R4 sel pin", {31'd0, ctl_sel_n}, 32'd0);
    chk("R4 oe", {31'd0, ctl_tx_oe}, 32'd1);
    chk("R4 data bit0", {24'd0, ctl_tx_n}, 32'h0FE);
    chk("R3 parity with sel", {31'd0, ctl_tx_par_n}, {31'd0, ~oddp(8'h01)});

    // R2 unused bits have no effect
    ctl_io_n = 1'b1;
    ctl_req_n = 1'b0;
    wr(WBASE + 1, 8'hA4);
    @(negedge clk);
    chk("R2 unused sel", {31'd0, ctl_sel_n}, 32'd1);
    chk("R2 unused oe", {31'd0, ctl_tx_oe}, 32'd0);
    chk("R2 unused dma", {31'd0, dma_en}, 32'd0);
    chk("R2 unused irq", {31'd0, irq}, 32'd0);
    ctl_req_n = 1'b1;
    wr(WBASE + 1, 8'h01);
    chk("R2 dma enable", {31'd0, dma_en}, 32'd1);

    // R3 outgoing data and parity, R9 ack timing
    ctl_io_n = 1'b0;
    wr(WBASE + 1, 8'h02);
    for (int i = 0; i < 20; i++) begin
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
      wr(WBASE + 0, b);
      chk("R9 ack low", {31'd0, ctl_ack_n}, 32'd0);
      chk("R3 tx data", {24'd0, ctl_tx_n}, {24'd0, ~b});
      chk("R3 tx parity", {31'd0, ctl_tx_par_n}, {31'd0, ~oddp(b)});
      chk("R3 oe", {31'd0, ctl_tx_oe}, 32'd1);
      @(negedge clk);
      chk("R9 ack single", {31'd0, ctl_ack_n}, 32'd1);
      chk("R3 hold", {24'd0, ctl_tx_n}, {24'd0, ~b});
    end
    ctl_io_n = 1'b1;
    #1 chk("R3 no drive toward host", {31'd0, ctl_tx_oe}, 32'd0);
    @(negedge clk);

    // R5/R6 incoming capture and parity check
    for (int i = 0; i < 24; i++) begin
      wr(WBASE + 1, 8'h00);
      b = 8'($urandom);
      good = (i < 2) ? 1'b1 : 1'($urandom);
      ctl_rx_n = ~b;
      ctl_rx_par_n = ~(good ? oddp(b) : ~oddp(b));
      req_pulse();
      ctl_rx_n = 8'($urandom);
      @(negedge clk);
      rd(WBASE + 0, v);
      chk("R5 rx byte held", {24'd0, v}, {24'd0, b});
      rd(WBASE + 2, v);
      chk("R6 parity flag", {31'd0, v[2]}, {31'd0, ~good});
    end
    wr(WBASE + 1, 8'h00);
    rd(WBASE + 2, v);
    chk("R6 cleared by control write", {31'd0, v[2]}, 32'd0);

    // R5 no capture while direction toward controller
    ctl_rx_n = 8'h5A; ctl_io_n = 1'b0;
    req_pulse();
    ctl_io_n = 1'b1;
    rd(WBASE + 0, b);
    ctl_rx_n = ~8'h3C; ctl_rx_par_n = ~oddp(8'h3C);
    req_pulse();
    rd(WBASE + 0, v);
    chk("R5 capture toward host", {24'd0, v}, 32'h3C);
    chk("R5 earlier value not 5A", {31'd0, b == 8'hA5}, 32'd0);

    // R7/R12 status layout
    for (int i = 0; i < 24; i++) begin
      toc = 1'($urandom);
      rq = toc & 1'($urandom);
      ctl_io_n = ~toc; ctl_req_n = ~rq;
      ctl_msg_n = 1'($urandom); ctl_cd_n = 1'($urandom); ctl_busy_n = 1'($urandom);
      dma_done = 1'($urandom);
      @(negedge clk);
      rd(WBASE + 2, v);
      chk("R7 status", {24'd0, v},
          {24'd0, stat_exp(rq, toc, ~ctl_msg_n, ~ctl_cd_n, ~ctl_busy_n, 1'b0, 1'b0, dma_done)});
      chk("R12 done bit", {31'd0, v[0]}, {31'd0, dma_done});
    end
    ctl_req_n = 1'b1; ctl_io_n = 1'b1; ctl_msg_n = 1'b1; ctl_cd_n = 1'b1;
    ctl_busy_n = 1'b1; dma_done = 1'b0;
    @(negedge clk);

    // R8 interrupt
    ctl_rx_n = ~8'h01; ctl_rx_par_n = 1'b1;
    wr(WBASE + 1, 8'h10);
    ctl_req_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 single enable no irq", {31'd0, irq}, 32'd0);
    ctl_req_n = 1'b1;
    wr(WBASE + 1, 8'h18);
    chk("R8 no irq without request", {31'd0, irq}, 32'd0);
    ctl_req_n = 1'b0;
    @(negedge clk);
    chk("R8 irq set", {31'd0, irq}, 32'd1);
    ctl_req_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 irq sticky", {31'd0, irq}, 32'd1);
    rd(WBASE + 2, v);
    chk("R8 status shows irq", {31'd0, v[1]}, 32'd1);
    chk("R8 irq cleared by status read", {31'd0, irq}, 32'd0);
    wr(WBASE + 1, 8'h00);

    // R10 completion status
    for (int i = 0; i < 4; i++) begin
      b = 8'($urandom);
      ctl_rx_n = ~b; cstat_ld = 1'b1;
      @(negedge clk);
      cstat_ld = 1'b0; ctl_rx_n = 8'($urandom);
      rd(WBASE + 1, v);
      chk("R10 completion status", {24'd0, v}, {24'd0, b});
    end

    // R11 auxiliary strobes
    io_addr = WBASE + 3; io_wdata = 8'hC3; io_wr = 1'b1;
    #2 chk("R11 addr write strobe", {31'd0, dma_addr_wr}, 32'd1);
    chk("R11 addr byte", {24'd0, dma_addr_byte}, 32'hC3);
    chk("R11 no boot strobe on write", {31'd0, boot_off_rd}, 32'd0);
    @(negedge clk); io_wr = 1'b0;
    io_rd = 1'b1;
    #2 chk("R11 boot read strobe", {31'd0, boot_off_rd}, 32'd1);
    chk("R11 no write strobe on read", {31'd0, dma_addr_wr}, 32'd0);
    @(negedge clk); io_rd = 1'b0;
    io_addr = WBASE + 3 ^ 16'h0400; io_rd = 1'b1;
    #2 chk("R1 R11 no strobe off-base", {31'd0, boot_off_rd}, 32'd0);
    @(negedge clk); io_rd = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule